// File: doc/BRIEF.md
# Software Flow-Control Character Filter

This block sits between a UART receiver and its receive FIFO. Every character the receiver finishes is offered on `rx_valid`/`rx_char`. The block watches for two programmable two-character sequences: a pause pair and a resume pair. When the pause pair arrives, it raises `tx_pause` toward the local transmitter. When the resume pair arrives, it drops `tx_pause`. Characters that complete either pair are consumed. All other characters go on to the FIFO.

The first character of a pair is held back until the next character decides its fate. If the pair is broken, the held character and the new one may both need to be written in the same cycle. For that reason the FIFO side has two ordered write lanes. Lane 0 is always the older character.

Two further options are available. In resume-on-any mode, any character received while paused resumes the transmitter. A separate detector flags every character equal to the second pause character.

Top module: `swflow_detect`

## Requirements
- R1: After reset, `tx_pause`, `xoff_irq`, `special_hit`, `wr0_en` and `wr1_en` are all 0.
- R2: With `flow_en`=1, no pair pending and not paused in resume-on-any mode, a character that equals neither `xoff1_chr` nor `xon1_chr` appears on lane 0 (`wr0_en`=1, `wr0_char`) in the cycle after it is accepted.
- R3: A character equal to `xoff1_chr` followed by one equal to `xoff2_chr` sets `tx_pause` to 1 in the cycle after the second is accepted. Neither character is written.
- R4: A character equal to `xon1_chr` followed by one equal to `xon2_chr` clears `tx_pause` in the cycle after the second is accepted. Neither character is written.
- R5: If the character after a held first character does not complete the pair, the held character is written on lane 0. The new character is then handled as a fresh one: it is forwarded on lane 1, or held as a new first character. `xoff1_chr` is tested before `xon1_chr`.
- R6: With `xon_any_en`=1 while paused, the next character clears `tx_pause`. That character is forwarded on lane 0, unless it equals `xon1_chr`, in which case it is consumed and a following `xon2_chr` is forwarded as plain data.
- R7: With `special_en`=1, every accepted character equal to `xoff2_chr` gives a one-cycle `special_hit` in the next cycle. Forwarding of that character is unaffected.
- R8: Completing the pause pair pulses `xoff_irq` for one cycle, together with the rise of `tx_pause`, only when `xoff_irq_en`=1.
- R9: With `flow_en`=0, `tx_pause` is 0 in the next cycle, a held first character is flushed on lane 0, and every character is forwarded unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flow_en | input | 1 | Enables software flow control |
| xon_any_en | input | 1 | Resume on any character while paused |
| special_en | input | 1 | Enables the second-pause-character detector |
| xoff_irq_en | input | 1 | Enables the pause-received pulse |
| xon1_chr | input | W | First resume character |
| xon2_chr | input | W | Second resume character |
| xoff1_chr | input | W | First pause character |
| xoff2_chr | input | W | Second pause character |
| rx_valid | input | 1 | A received character is offered this cycle |
| rx_char | input | W | Received character |
| wr0_en | output | 1 | Write the older character to the FIFO |
| wr0_char | output | W | Older character |
| wr1_en | output | 1 | Write a second, newer character after lane 0 |
| wr1_char | output | W | Newer character |
| tx_pause | output | 1 | Holds off the local transmitter |
| xoff_irq | output | 1 | One-cycle pause-received pulse |
| special_hit | output | 1 | One-cycle second-pause-character match |

## Verification
Every result of this block is registered exactly once. Lane writes, `tx_pause` changes, `xoff_irq` and `special_hit` are all due in the first cycle after the clock edge that accepts the character or the `flow_en` change. The bench therefore advances its behavioural model at each rising edge. It compares all outputs at the following falling edge, in every cycle, including idle cycles where nothing may be written. Scenarios cover broken pairs, back-to-back characters and disabling with a character held, so that two-lane cycles and flush cycles are checked at that one-cycle offset.

// File: rtl/swflow_detect.sv
module swflow_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flow_en,
  input  logic         xon_any_en,
  input  logic         special_en,
  input  logic         xoff_irq_en,
  input  logic [W-1:0] xon1_chr,
  input  logic [W-1:0] xon2_chr,
  input  logic [W-1:0] xoff1_chr,
  input  logic [W-1:0] xoff2_chr,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_char,
  output logic         wr0_en,
  output logic [W-1:0] wr0_char,
  output logic         wr1_en,
  output logic [W-1:0] wr1_char,
  output logic         tx_pause,
  output logic         xoff_irq,
  output logic         special_hit
);

  typedef enum logic [1:0] {IDLE, HOLD_OFF, HOLD_ON} hold_e;

  hold_e        st_q, st_d;
  logic [W-1:0] held_q, held_d;
  logic         pause_d, irq_d, w0_d, w1_d;
  logic [W-1:0] c0_d, c1_d;
  logic         pend, pair_done, fwd, use_l1;

  assign pend      = (st_q != IDLE);
  assign pair_done = pend && ((st_q == HOLD_OFF) ? (rx_char == xoff2_chr)
                                                 : (rx_char == xon2_chr));

  always_comb begin
    st_d    = st_q;
    held_d  = held_q;
    pause_d = tx_pause;
    irq_d   = 1'b0;
    w0_d    = 1'b0;
    c0_d    = held_q;
    w1_d    = 1'b0;
    c1_d    = rx_char;
    fwd     = 1'b0;
    use_l1  = 1'b0;
    if (!flow_en) begin
      pause_d = 1'b0;
      st_d    = IDLE;
      w0_d    = pend;
      use_l1  = pend;
      fwd     = rx_valid;
    end else if (rx_valid) begin
      if (pair_done) begin
        st_d = IDLE;
        if (st_q == HOLD_OFF) begin
          pause_d = 1'b1;
          irq_d   = xoff_irq_en;
        end else begin
          pause_d = 1'b0;
        end
      end else begin
        w0_d   = pend;
        use_l1 = pend;
        st_d   = IDLE;
        if (tx_pause && xon_any_en) begin
          pause_d = 1'b0;
          fwd     = (rx_char != xon1_chr);
        end else if (rx_char == xoff1_chr) begin
          st_d   = HOLD_OFF;
          held_d = rx_char;
        end else if (rx_char == xon1_chr) begin
          st_d   = HOLD_ON;
          held_d = rx_char;
        end else begin
          fwd = 1'b1;
        end
      end
    end
    if (fwd) begin
      if (use_l1) begin
        w1_d = 1'b1;
      end else begin
        w0_d = 1'b1;
        c0_d = rx_char;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= IDLE;
      held_q      <= '0;
      tx_pause    <= 1'b0;
      xoff_irq    <= 1'b0;
      special_hit <= 1'b0;
      wr0_en      <= 1'b0;
      wr0_char    <= '0;
      wr1_en      <= 1'b0;
      wr1_char    <= '0;
    end else begin
      st_q        <= st_d;
      held_q      <= held_d;
      tx_pause    <= pause_d;
      xoff_irq    <= irq_d;
      special_hit <= special_en && rx_valid && (rx_char == xoff2_chr);
      wr0_en      <= w0_d;
      wr0_char    <= c0_d;
      wr1_en      <= w1_d;
      wr1_char    <= c1_d;
    end
  end

  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> wr0_en); // R5
  AST_PAUSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> $past(rx_valid && rx_char == xoff2_chr && flow_en)); // R3
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |=> !tx_pause); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_irq |-> (tx_pause && $past(xoff_irq_en))); // R8
  AST_SPECIAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    special_hit |-> $past(special_en && rx_valid)); // R7
  AST_RESUME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_pause) |-> $past(!flow_en || rx_valid)); // R4

endmodule

// File: tb/swflow_detect_bench.sv
module swflow_detect_bench;
  localparam int W = 8;
  localparam logic [W-1:0] XON1 = 8'h11, XON2 = 8'h13, XOFF1 = 8'h19, XOFF2 = 8'h17;

  logic clk = 0, rst_n = 0;
  logic flow_en = 1, xon_any_en = 0, special_en = 0, xoff_irq_en = 0;
  logic rx_valid = 0;
  logic [W-1:0] rx_char = '0;
  logic wr0_en, wr1_en, tx_pause, xoff_irq, special_hit;
  logic [W-1:0] wr0_char, wr1_char;

  int tests = 0, fails = 0;
  string req = "R1";

  int m_pk = 0;
  logic [W-1:0] m_held = '0;
  bit m_pause = 0;
  bit e_irq, e_sp;
  logic [W-1:0] outq[$];

  always #5 clk = ~clk;

  swflow_detect #(.W(W)) u_swflow_detect (
    .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .xon_any_en(xon_any_en),
    .special_en(special_en), .xoff_irq_en(xoff_irq_en),
    .xon1_chr(XON1), .xon2_chr(XON2), .xoff1_chr(XOFF1), .xoff2_chr(XOFF2),
    .rx_valid(rx_valid), .rx_char(rx_char),
    .wr0_en(wr0_en), .wr0_char(wr0_char), .wr1_en(wr1_en), .wr1_char(wr1_char),
    .tx_pause(tx_pause), .xoff_irq(xoff_irq), .special_hit(special_hit));

  task automatic chk(input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    outq.delete();
    e_irq = 0;
    e_sp  = special_en && rx_valid && rx_char == XOFF2;
    if (!flow_en) begin
      if (m_pk != 0) outq.push_back(m_held);
      m_pk = 0;
      m_pause = 0;
      if (rx_valid) outq.push_back(rx_char);
    end else if (rx_valid) begin
      if (m_pk == 1 && rx_char == XOFF2) begin
        m_pause = 1; e_irq = xoff_irq_en; m_pk = 0;
      end else if (m_pk == 2 && rx_char == XON2) begin
        m_pause = 0; m_pk = 0;
      end else begin
        if (m_pk != 0) outq.push_back(m_held);
        m_pk = 0;
        if (m_pause && xon_any_en) begin
          m_pause = 0;
          if (rx_char != XON1) outq.push_back(rx_char);
        end else if (rx_char == XOFF1) begin
          m_pk = 1; m_held = rx_char;
        end else if (rx_char == XON1) begin
          m_pk = 2; m_held = rx_char;
        end else outq.push_back(rx_char);
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("wr0_en", wr0_en, outq.size() > 0);
    if (outq.size() > 0) chk("wr0_char", wr0_char, outq[0]);
    chk("wr1_en", wr1_en, outq.size() > 1);
    if (outq.size() > 1) chk("wr1_char", wr1_char, outq[1]);
    chk("tx_pause", tx_pause, m_pause);
    chk("xoff_irq", xoff_irq, e_irq);
    chk("special_hit", special_hit, e_sp);
    rx_valid = 0;
  endtask

  task automatic send(input logic [W-1:0] c, input int gap);
    rx_valid = 1; rx_char = c;
    cyc();
    for (int i = 0; i < gap; i++) cyc();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #23;
    req = "R1";
    chk("reset tx_pause", tx_pause, 0);
    chk("reset wr0_en", wr0_en, 0);
    chk("reset wr1_en", wr1_en, 0);
    chk("reset xoff_irq", xoff_irq, 0);
    chk("reset special_hit", special_hit, 0);
    @(negedge clk); rst_n = 1;
    cyc();
    req = "R2"; send(8'h41, 1); send(8'h42, 0); send(8'h43, 2);
    req = "R3"; xoff_irq_en = 0; send(XOFF1, 1); send(XOFF2, 1);
    req = "R4"; send(XON1, 0); send(XON2, 2);
    req = "R8"; xoff_irq_en = 1; send(XOFF1, 0); send(XOFF2, 1);
    req = "R4"; send(XON1, 1); send(XON2, 1);
    req = "R5"; send(XOFF1, 0); send(8'h55, 1);
    send(XON1, 0); send(XOFF1, 0); send(XON1, 0); send(8'h66, 1);
    send(XOFF1, 0); send(XON2, 1);
    req = "R6"; xon_any_en = 1; send(XOFF1, 0); send(XOFF2, 1);
    send(8'h60, 1); send(XOFF1, 0); send(XOFF2, 0);
    send(XON1, 0); send(XON2, 2);
    send(XOFF1, 0); send(XOFF2, 0); send(XOFF1, 1);
    xon_any_en = 0;
    req = "R7"; special_en = 1; send(XOFF2, 1); send(8'h70, 0);
    send(XOFF1, 0); send(XOFF2, 1); special_en = 0; send(XOFF2, 1);
    req = "R9"; send(XOFF1, 0); flow_en = 0; cyc(); cyc();
    send(XOFF1, 0); send(XOFF2, 0); send(XON1, 1);
    flow_en = 1; send(XOFF1, 0); send(XOFF2, 1);
    send(XON1, 0); flow_en = 0; rx_valid = 1; rx_char = 8'h77; cyc(); cyc();
    chk("tx_pause after disable", tx_pause, 0);
    flow_en = 1; send(8'h7A, 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule